// File: doc/BRIEF.md
# Link Sequence Numbering and Replay

This block is the reliability core of a point-to-point link layer. On the sending side it gives every packet from the upper layer a 12-bit sequence number. It sends the packet out with that number and keeps a copy in a small replay store until the far end acknowledges it. An acknowledgement (ACK) carrying number N releases every stored packet up to and including N. A negative acknowledgement (NAK) carrying N releases the same packets and then resends every packet still stored after N. The resent packets go out in their original order and keep their original numbers.

On the receiving side the block compares each arriving packet with the number it expects next and looks at the integrity flag supplied by an external checker. A packet with the expected number and a good flag is forwarded upward and acknowledged. Any other packet is discarded. The block answers it with an ACK if it is an old duplicate, or with a NAK if it is corrupt or arrives ahead of a gap. Both kinds of answer carry the last good number.

Top module: `link_seq_replay`

## Requirements
- R1: After reset the first accepted upper-layer packet carries number 0. Each later new packet carries the previous number plus one, modulo 4096. The number appears on `tx_seq` and the payload on `tx_data`.
- R2: `up_ready` is low whenever DEPTH packets (default 8) are stored and not yet acknowledged.
- R3: An ACK with number N, where N lies in the range from the oldest stored number minus one to the newest stored number (modulo 4096), frees every stored packet up to and including N. An ACK outside that range has no effect.
- R4: A NAK with number N that lies in the same range frees packets up to and including N. One cycle later, and from then on one per cycle, it resends every remaining stored packet in original order with its original number and payload.
- R5: `up_ready` is low in any cycle with `nak_valid` high and in every cycle while a replay is still pending.
- R6: A packet accepted on a clock edge (`up_valid` and `up_ready` both high) appears on the `tx_*` outputs after that edge, for exactly one cycle.
- R7: After reset the receiver expects number 0. A packet with `rx_good` high and the expected number is forwarded on `fwd_*` on the next cycle, together with an ACK (`rsp_ack`) whose `rsp_seq` equals its number. The expected number then advances modulo 4096.
- R8: A packet with `rx_good` low is not forwarded. It is answered on the next cycle with `rsp_nak` and `rsp_seq` equal to the expected number minus one.
- R9: A good packet whose number is 1 to 2048 behind the expected number (modulo 4096) is dropped. It is answered with `rsp_ack` carrying the expected number minus one, and `rsp_ack` and `rsp_nak` are never high together.
- R10: A good packet whose number is otherwise not the expected one is dropped and answered with `rsp_nak` carrying the expected number minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upper layer offers a packet |
| up_data | input | DW | Upper-layer payload |
| up_ready | output | 1 | Packet accepted when high with up_valid |
| tx_valid | output | 1 | Outgoing tagged packet valid |
| tx_seq | output | SW | Sequence number of outgoing packet |
| tx_data | output | DW | Payload of outgoing packet |
| ack_valid | input | 1 | ACK received from far end |
| ack_seq | input | SW | Number carried by ACK |
| nak_valid | input | 1 | NAK received from far end (wins over ACK) |
| nak_seq | input | SW | Number carried by NAK |
| rx_valid | input | 1 | Incoming packet valid |
| rx_seq | input | SW | Incoming packet number |
| rx_data | input | DW | Incoming payload |
| rx_good | input | 1 | Integrity check of incoming packet passed |
| fwd_valid | output | 1 | Accepted packet forwarded upward |
| fwd_seq | output | SW | Number of forwarded packet |
| fwd_data | output | DW | Payload of forwarded packet |
| rsp_ack | output | 1 | Receiver issues ACK |
| rsp_nak | output | 1 | Receiver issues NAK |
| rsp_seq | output | SW | Number carried by issued ACK/NAK |

## Verification
Every result of this block is registered once. A new packet appears on `tx_*` after the edge that accepts it. The receiver's forward and ACK/NAK answer appear after the edge that samples the incoming packet. The bench drives inputs on the falling edge and reads these outputs on the next falling edge. A NAK produces nothing on its own edge. Its replayed packets follow on each later edge, so the bench logs every falling edge with `tx_valid` high and compares the logged order afterwards. `up_ready` is read on the falling edge after an ACK or NAK, which is when the freed store and the pending replay become visible.

// File: rtl/link_seq_replay.sv
module link_seq_replay #(
  parameter int SW    = 12,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  input  logic [DW-1:0] up_data,
  output logic          up_ready,
  output logic          tx_valid,
  output logic [SW-1:0] tx_seq,
  output logic [DW-1:0] tx_data,
  input  logic          ack_valid,
  input  logic [SW-1:0] ack_seq,
  input  logic          nak_valid,
  input  logic [SW-1:0] nak_seq,
  input  logic          rx_valid,
  input  logic [SW-1:0] rx_seq,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_good,
  output logic          fwd_valid,
  output logic [SW-1:0] fwd_seq,
  output logic [DW-1:0] fwd_data,
  output logic          rsp_ack,
  output logic          rsp_nak,
  output logic [SW-1:0] rsp_seq
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [SW-1:0] ONE  = SW'(1);
  localparam logic [SW-1:0] FULL = SW'(DEPTH);
  localparam logic [SW-1:0] HALF = SW'(1) << (SW - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [SW-1:0] head, nxt, rp, expd;

  wire [SW-1:0] cnt      = nxt - head;
  wire          rpl      = rp != nxt;
  wire [SW-1:0] ack_head = ack_seq + ONE;
  wire [SW-1:0] nak_head = nak_seq + ONE;
  wire [SW-1:0] ack_d    = ack_head - head;
  wire [SW-1:0] nak_d    = nak_head - head;
  wire          ack_ok   = ack_valid && ack_d <= cnt;
  wire          nak_ok   = nak_valid && nak_d <= cnt;
  wire          ack_jump = ack_ok && ack_d > (rp - head);
  wire          accept   = up_valid && up_ready;

  assign up_ready = !rpl && !nak_valid && cnt < FULL;

  always_ff @(posedge clk)
    if (accept) mem[nxt[IW-1:0]] <= up_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head     <= '0;
      nxt      <= '0;
      rp       <= '0;
      tx_valid <= 1'b0;
      tx_seq   <= '0;
      tx_data  <= '0;
    end else begin
      tx_valid <= 1'b0;
      if (nak_ok) begin
        head <= nak_head;
        rp   <= nak_head;
      end else begin
        if (ack_ok) head <= ack_head;
        if (ack_jump) begin
          rp <= ack_head;
        end else if (rpl) begin
          tx_valid <= 1'b1;
          tx_seq   <= rp;
          tx_data  <= mem[rp[IW-1:0]];
          rp       <= rp + ONE;
        end else if (accept) begin
          tx_valid <= 1'b1;
          tx_seq   <= nxt;
          tx_data  <= up_data;
          nxt      <= nxt + ONE;
          rp       <= rp + ONE;
        end
      end
    end
  end

  wire [SW-1:0] last   = expd - ONE;
  wire [SW-1:0] behind = expd - rx_seq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      expd      <= '0;
      fwd_valid <= 1'b0;
      fwd_seq   <= '0;
      fwd_data  <= '0;
      rsp_ack   <= 1'b0;
      rsp_nak   <= 1'b0;
      rsp_seq   <= '0;
    end else begin
      fwd_valid <= 1'b0;
      rsp_ack   <= 1'b0;
      rsp_nak   <= 1'b0;
      if (rx_valid) begin
        if (!rx_good) begin
          rsp_nak <= 1'b1;
          rsp_seq <= last;
        end else if (rx_seq == expd) begin
          fwd_valid <= 1'b1;
          fwd_seq   <= rx_seq;
          fwd_data  <= rx_data;
          rsp_ack   <= 1'b1;
          rsp_seq   <= rx_seq;
          expd      <= expd + ONE;
        end else if (behind <= HALF) begin
          rsp_ack <= 1'b1;
          rsp_seq <= last;
        end else begin
          rsp_nak <= 1'b1;
          rsp_seq <= last;
        end
      end
    end
  end
endmodule

// File: rtl/link_seq_replay_chk.sv
module link_seq_replay_chk #(
  parameter int SW = 12,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          up_valid,
  input logic [DW-1:0] up_data,
  input logic          up_ready,
  input logic          tx_valid,
  input logic [SW-1:0] tx_seq,
  input logic [DW-1:0] tx_data,
  input logic          nak_valid,
  input logic          rx_valid,
  input logic          rx_good,
  input logic          fwd_valid,
  input logic [SW-1:0] fwd_seq,
  input logic          rsp_ack,
  input logic          rsp_nak,
  input logic [SW-1:0] rsp_seq
);
  assert_tx_follows_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> (tx_valid && tx_data == $past(up_data)));

  assert_tx_seq_consecutive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && $past(tx_valid)) |-> tx_seq == $past(tx_seq) + SW'(1));

  assert_nak_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nak_valid |-> !up_ready);

  assert_rx_bad_naked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_good) |=> (rsp_nak && !fwd_valid));

  assert_rx_fwd_acked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (rsp_ack && rsp_seq == fwd_seq));

  assert_rsp_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_ack && rsp_nak));
endmodule

bind link_seq_replay link_seq_replay_chk #(.SW(SW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_data(up_data),
  .up_ready(up_ready), .tx_valid(tx_valid), .tx_seq(tx_seq), .tx_data(tx_data),
  .nak_valid(nak_valid), .rx_valid(rx_valid), .rx_good(rx_good),
  .fwd_valid(fwd_valid), .fwd_seq(fwd_seq), .rsp_ack(rsp_ack),
  .rsp_nak(rsp_nak), .rsp_seq(rsp_seq)
);

// File: tb/tb_link_seq_replay.sv
`timescale 1ns/1ps
module tb_link_seq_replay;
  localparam int SW = 12, DW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic up_valid = 1'b0, ack_valid = 1'b0, nak_valid = 1'b0, rx_valid = 1'b0, rx_good = 1'b0;
  logic [DW-1:0] up_data = '0, rx_data = '0;
  logic [SW-1:0] ack_seq = '0, nak_seq = '0, rx_seq = '0;
  logic up_ready, tx_valid, fwd_valid, rsp_ack, rsp_nak;
  logic [SW-1:0] tx_seq, fwd_seq, rsp_seq;
  logic [DW-1:0] tx_data, fwd_data;

  link_seq_replay dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int gcnt = 0;
  int got_seq [64];
  int got_data [64];

  always @(negedge clk)
    if (tx_valid && gcnt < 64) begin
      got_seq[gcnt]  = int'(tx_seq);
      got_data[gcnt] = int'(tx_data);
      gcnt = gcnt + 1;
    end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int d);
    @(negedge clk); up_valid = 1'b1; up_data = DW'(d);
    @(negedge clk); up_valid = 1'b0;
  endtask

  task automatic ack(input int n);
    @(negedge clk); ack_valid = 1'b1; ack_seq = SW'(n);
    @(negedge clk); ack_valid = 1'b0;
  endtask

  task automatic nak(input int n);
    @(negedge clk); nak_valid = 1'b1; nak_seq = SW'(n);
    @(negedge clk); nak_valid = 1'b0;
  endtask

  task automatic rxp(input int s, input bit g, input int d);
    @(negedge clk); rx_valid = 1'b1; rx_seq = SW'(s); rx_good = g; rx_data = DW'(d);
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic rx_expect(input string req, input bit f, input bit a, input int s);
    chk(fwd_valid == f, req, "fwd_valid", int'(fwd_valid), int'(f));
    chk(rsp_ack == a, req, "rsp_ack", int'(rsp_ack), int'(a));
    chk(rsp_nak == !a, req, "rsp_nak", int'(rsp_nak), int'(!a));
    chk(int'(rsp_seq) == s, req, "rsp_seq", int'(rsp_seq), s);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 R7 reset state
    chk(up_ready == 1'b1, "R1", "reset up_ready", int'(up_ready), 1);
    chk(tx_valid == 1'b0, "R1", "reset tx_valid", int'(tx_valid), 0);
    chk(fwd_valid == 1'b0, "R7", "reset fwd_valid", int'(fwd_valid), 0);
    chk(rsp_ack == 1'b0 && rsp_nak == 1'b0, "R7", "reset rsp", int'(rsp_ack), 0);

    // R1 R6: fill store
    gcnt = 0;
    for (int i = 0; i < 8; i++) send(32'hA000 + i);
    idle(1);
    chk(gcnt == 8, "R6", "sent count", gcnt, 8);
    for (int i = 0; i < 8; i++) begin
      chk(got_seq[i] == i, "R1", "tx_seq", got_seq[i], i);
      chk(got_data[i] == 32'hA000 + i, "R6", "tx_data", got_data[i], 32'hA000 + i);
    end
    chk(up_ready == 1'b0, "R2", "full store", int'(up_ready), 0);

    // R3 ACK frees, out-of-range ACK ignored
    ack(2);
    chk(up_ready == 1'b1, "R3", "after ack 2", int'(up_ready), 1);
    ack(100);

    // R4 R5 NAK replays 3..7
    gcnt = 0;
    nak(2);
    chk(up_ready == 1'b0, "R5", "during replay", int'(up_ready), 0);
    idle(7);
    chk(gcnt == 5, "R4", "replay count (ack 100 ignored, R3)", gcnt, 5);
    for (int i = 0; i < 5; i++) begin
      chk(got_seq[i] == 3 + i, "R4", "replay seq", got_seq[i], 3 + i);
      chk(got_data[i] == 32'hA003 + i, "R4", "replay data", got_data[i], 32'hA003 + i);
    end
    chk(up_ready == 1'b1, "R5", "after replay", int'(up_ready), 1);

    ack(4);
    gcnt = 0;
    nak(5);
    idle(4);
    chk(gcnt == 2, "R4", "second replay count", gcnt, 2);
    chk(got_seq[0] == 6 && got_seq[1] == 7, "R4", "second replay seq", got_seq[0], 6);
    ack(7);

    // R1 wrap sweep
    for (int i = 8; i < 4200; i++) begin
      chk(up_ready == 1'b1, "R2", "ready when empty", int'(up_ready), 1);
      send(i);
      chk(tx_valid && int'(tx_seq) == (i % 4096), "R1", "wrap seq", int'(tx_seq), i % 4096);
      ack(i % 4096);
    end

    // R7 R8 R9 R10 receiver
    rxp(0, 1'b1, 32'h55);
    rx_expect("R7", 1'b1, 1'b1, 0);
    chk(fwd_data == 32'h55, "R7", "fwd_data", int'(fwd_data), 32'h55);
    rxp(5, 1'b1, 1);
    rx_expect("R10", 1'b0, 1'b0, 0);
    rxp(1, 1'b0, 2);
    rx_expect("R8", 1'b0, 1'b0, 0);
    rxp(0, 1'b1, 3);
    rx_expect("R9", 1'b0, 1'b1, 0);
    for (int k = 1; k < 4200; k++) begin
      rxp(k % 4096, 1'b1, k);
      rx_expect("R7", 1'b1, 1'b1, k % 4096);
      chk(int'(fwd_seq) == k % 4096, "R7", "fwd_seq", int'(fwd_seq), k % 4096);
      if (k % 300 == 0) begin
        rxp((k - 3) % 4096, 1'b1, 0);
        rx_expect("R9", 1'b0, 1'b1, k % 4096);
        rxp((k + 10) % 4096, 1'b1, 0);
        rx_expect("R10", 1'b0, 1'b0, k % 4096);
        rxp((k + 1) % 4096, 1'b0, 0);
        rx_expect("R8", 1'b0, 1'b0, k % 4096);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule